// File: doc/BRIEF.md
# Queue-Framed SPI Master

This block is an SPI master that shifts words out on MOSI and captures MISO, with a 16-entry transmit queue and a 16-entry receive queue between it and the rest of the chip. Software or a state machine pushes transmit words through a one-cycle write strobe. Received words come back through a read strobe, and the head of the receive queue is always visible on the read data port.

No start command exists. A word that arrives while the shifter is idle is loaded on the next clock and shifting begins. Words that arrive during a transfer wait in the queue and follow without a pause. The active-low chip select drops when the first word is loaded and stays low across every queued word. It rises only after the last word has finished and the queue is empty. The queue's occupancy therefore sets the frame: a multi-word device instruction is framed by writing all of its words before the first one finishes.

Three configuration inputs set the word length (1 to 16 bits), the clock polarity and phase, and a divider for the bit rate. Between frames the serial clock stays at its idle level.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, cs_n is 1, sclk equals cfg_cpol, tx_level is 0, tx_full is 0, rx_empty is 1 and rx_ovf is 0.
- R2: A word written while idle (no word shifting, queue empty) is taken on the clock edge after the write. cs_n goes low at that edge with no other command.
- R3: One sclk half-period lasts cfg_div+1 clocks. The first sclk edge of a frame comes one half-period after cs_n falls. cs_n rises one half-period after the last edge of the frame.
- R4: Queued words shift back to back. The next word loads at the final edge of the current one, and its first edge follows one half-period later. cs_n stays low until the queue is empty and the last word is complete.
- R5: While cs_n is high, sclk rests at cfg_cpol and does not toggle. Each word produces exactly 2·(cfg_bits_m1+1) sclk edges.
- R6: The word length is cfg_bits_m1+1. Bits [cfg_bits_m1:0] of the transmit word go out on MOSI with the most significant bit first.
- R7: With cfg_cpha=0, MISO is sampled on the first, third, … edges of a word and MOSI changes on the others. With cfg_cpha=1, MISO is sampled on the second, fourth, … edges and MOSI changes on the third, fifth, … edges.
- R8: Each completed word stores exactly one word in the receive queue. The captured bits are right-justified, the first bit received is the MSB, and the unused upper bits are 0.
- R9: Each queue holds 16 words. tx_level reports the transmit occupancy and tx_full is 1 at 16. A write to a full transmit queue is dropped unless the shifter takes a word from the queue on that same edge.
- R10: A received word that arrives while the receive queue is full, with no read on that edge, is discarded and sets rx_ovf. rx_ovf then stays set until reset. rx_rd while the receive queue is empty has no effect.
- R11: A transmit write and a shifter load on the same edge both take effect. A receive read and a received-word store on the same edge both take effect. rx_data always shows the oldest unread word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bits_m1 | input | 4 | Word length minus one |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_div | input | 8 | Half-period of sclk minus one, in clocks |
| tx_wr | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | 16 | Transmit word, low-order bits used |
| tx_level | output | 5 | Transmit queue occupancy |
| tx_full | output | 1 | Transmit queue holds 16 words |
| rx_rd | input | 1 | Pop the receive queue head |
| rx_data | output | 16 | Oldest unread received word |
| rx_empty | output | 1 | Receive queue has no words |
| rx_ovf | output | 1 | Sticky: a received word was lost |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two pairs of events can land on one clock edge. The first pair is a transmit write and the shifter's load from the same queue. The bench provokes it by writing twenty words on consecutive cycles at the fastest bit rate, so writes meet both loads and a full queue. The second pair is a read of the receive queue and the store of a finished word. The bench fills the receive queue, then raises rx_rd only during the cycle before the final edge of one more word. The reference model applies both operations of each pair on the same edge, and every cycle the bench compares queue levels, flags, the receive head, cs_n and sclk against it. Any lost or duplicated word shows up as a mismatch.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TRAIL = 2'd2
  } eng_state_t;

  // A word of (bits_m1+1) bits spans 2*(bits_m1+1) clock edges.
  function automatic logic final_edge(input int unsigned edge_no,
                                      input int unsigned bits_m1);
    return edge_no == (2 * bits_m1 + 1);
  endfunction

  // MISO capture happens on the edge parity equal to the phase setting.
  function automatic logic capture_edge(input logic edge_lsb, input logic cpha);
    return edge_lsb == cpha;
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_pop, do_push;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != FULL_CNT) || do_pop);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || tick)     cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int MAXW = 16,
  parameter int LW   = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cpha,
  input  logic [LW-1:0]   bits_m1,
  input  logic            tx_avail,
  input  logic [MAXW-1:0] tx_word,
  input  logic            miso,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [MAXW-1:0] rx_word,
  output logic            sclk_ph,
  output logic            mosi,
  output logic            busy,
  output logic            sh_edge
);
  eng_state_t      state;
  logic [MAXW-1:0] txw, rxw;
  logic [LW-1:0]   bit_idx;
  logic [LW:0]     edge_no;
  logic            is_last, is_cap, is_adv, load;

  assign sh_edge = (state == ENG_SHIFT) && tick;
  assign is_last = sh_edge && final_edge(int'(edge_no), int'(bits_m1));
  assign is_cap  = sh_edge && capture_edge(edge_no[0], cpha);
  assign is_adv  = sh_edge && !is_cap && !is_last && (edge_no != '0);
  assign load    = ((state == ENG_IDLE) || is_last) && tx_avail;

  assign tx_pop  = load;
  assign rx_push = is_last;
  assign rx_word = is_cap ? {rxw[MAXW-2:0], miso} : rxw;
  assign busy    = (state != ENG_IDLE);
  assign mosi    = (state == ENG_SHIFT) ? txw[bit_idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      txw     <= '0;
      rxw     <= '0;
      bit_idx <= '0;
      edge_no <= '0;
      sclk_ph <= 1'b0;
    end else begin
      if (sh_edge) sclk_ph <= ~sclk_ph;
      if (is_cap)  rxw <= {rxw[MAXW-2:0], miso};
      if (is_adv)  bit_idx <= bit_idx - 1'b1;
      if (sh_edge && !is_last) edge_no <= edge_no + 1'b1;
      if (is_last && !tx_avail) state <= ENG_TRAIL;
      if ((state == ENG_TRAIL) && tick) state <= ENG_IDLE;
      if (load) begin
        state   <= ENG_SHIFT;
        txw     <= tx_word;
        rxw     <= '0;
        bit_idx <= bits_m1;
        edge_no <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 16,
  parameter int MAXW  = 16,
  parameter int DIVW  = 8,
  parameter int LW    = $clog2(MAXW),
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   cfg_bits_m1,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            tx_wr,
  input  logic [MAXW-1:0] tx_data,
  output logic [CW-1:0]   tx_level,
  output logic            tx_full,
  input  logic            rx_rd,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_empty,
  output logic            rx_ovf,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0]   rx_count;
  logic [MAXW-1:0] tx_head, rx_word;
  logic            tx_pop, rx_push, tick, busy, sh_edge, sclk_ph, rx_full;

  spi_word_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(tx_data),
    .pop(tx_pop), .dout(tx_head), .count(tx_level));

  spi_word_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(rx_rd), .dout(rx_data), .count(rx_count));

  spi_baud_tick #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick));

  spi_shift_engine #(.MAXW(MAXW), .LW(LW)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cpha(cfg_cpha),
    .bits_m1(cfg_bits_m1), .tx_avail(tx_level != '0), .tx_word(tx_head),
    .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sclk_ph(sclk_ph), .mosi(mosi), .busy(busy), .sh_edge(sh_edge));

  assign tx_full  = (tx_level == FULL_CNT);
  assign rx_full  = (rx_count == FULL_CNT);
  assign rx_empty = (rx_count == '0);
  assign cs_n     = ~busy;
  assign sclk     = sclk_ph ^ cfg_cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rx_ovf <= 1'b0;
    else if (rx_push && rx_full && !rx_rd) rx_ovf <= 1'b1;
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          cfg_cpol,
  input logic [CW-1:0] tx_level,
  input logic          tx_full,
  input logic          rx_ovf,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          sh_edge,
  input logic          sclk_ph
);
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cfg_cpol));

  p_full_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> (tx_level == CW'(DEPTH)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf);

  p_store_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !cs_n);

  p_load_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !cs_n);

  p_toggle_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_edge |=> $stable(sclk_ph));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cfg_cpol(cfg_cpol),
  .tx_level(tx_level), .tx_full(tx_full), .rx_ovf(rx_ovf), .tx_pop(tx_pop),
  .rx_push(rx_push), .sh_edge(sh_edge), .sclk_ph(sclk_ph));

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_bits_m1 = 4'd7;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        tx_wr = 1'b0;
  logic [15:0] tx_data = '0;
  logic        rd_task = 1'b0, rd_auto = 1'b0, rx_rd;
  logic [4:0]  tx_level;
  logic        tx_full, rx_empty, rx_ovf, sclk, mosi, miso, cs_n;
  logic [15:0] rx_data;

  int checks = 0, fails = 0, dut_reads = 0;

  always #10 clk = ~clk;
  assign rx_rd = rd_task | rd_auto;
  assign miso  = ~mosi;

  spi_fifo_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bits_m1(cfg_bits_m1), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_level(tx_level), .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_ovf(rx_ovf), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: queues and counters, advanced on each rising edge.
  int q[$], rq[$];
  int m_st, m_cnt, m_e, cur, m_ph, pre, rpre, rword, nb, dv;
  bit m_ovf, popped, rpopped, push_rx;
  logic mosi_seen = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); rq.delete();
      m_st = 0; m_cnt = 0; m_e = 0; cur = 0; m_ph = 0; m_ovf = 0;
    end else begin
      nb = int'(cfg_bits_m1) + 1;
      dv = int'(cfg_div);
      pre = q.size(); popped = 0; push_rx = 0;
      if (m_st == 0) begin
        if (pre > 0) begin cur = q.pop_front(); popped = 1; m_st = 1; m_cnt = 0; m_e = 0; end
      end else if (m_cnt != dv) begin
        m_cnt++;
      end else begin
        m_cnt = 0;
        if (m_st == 2) m_st = 0;
        else begin
          if ((m_e % 2) == int'(cfg_cpha))   // R7 capture edge, R6 MSB first
            chk(mosi_seen === cur[nb-1-m_e/2], "R6/R7 mosi bit", int'(mosi_seen), cur[nb-1-m_e/2]);
          m_ph ^= 1;
          if (m_e == 2*nb-1) begin
            push_rx = 1;
            rword = (~cur) & ((1 << nb) - 1);
            if (pre > 0) begin cur = q.pop_front(); popped = 1; m_e = 0; end
            else m_st = 2;
          end else m_e++;
        end
      end
      if (tx_wr && (pre < 16 || popped)) q.push_back(int'(tx_data));
      rpre = rq.size(); rpopped = 0;
      if (rx_rd && rpre > 0) begin void'(rq.pop_front()); rpopped = 1; end
      if (push_rx) begin
        if (rpre < 16 || rpopped) rq.push_back(rword);
        else m_ovf = 1;
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      mosi_seen = mosi;
      chk(cs_n == (m_st == 0), "R2/R4 cs_n", int'(cs_n), int'(m_st == 0));
      chk(sclk == (m_ph[0] ^ cfg_cpol), "R3/R5 sclk", int'(sclk), int'(m_ph[0] ^ cfg_cpol));
      chk(int'(tx_level) == q.size(), "R9 tx_level", int'(tx_level), q.size());
      chk(tx_full == (q.size() == 16), "R9 tx_full", int'(tx_full), int'(q.size() == 16));
      chk(rx_empty == (rq.size() == 0), "R10 rx_empty", int'(rx_empty), int'(rq.size() == 0));
      chk(rx_ovf == m_ovf, "R10 rx_ovf", int'(rx_ovf), int'(m_ovf));
      if (rq.size() > 0)
        chk(int'(rx_data) == rq[0], "R8/R11 rx_data", int'(rx_data), rq[0]);
      if (rd_task && !rx_empty) dut_reads++;
    end
  end

  task automatic set_cfg(input int bits, input int div, input int mode);
    cfg_bits_m1 = 4'(bits - 1);
    cfg_div = 8'(div);
    cfg_cpol = mode[1];
    cfg_cpha = mode[0];
  endtask

  task automatic write_words(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_wr = 1'b1;
      tx_data = 16'(seed * 40503 + i * 7919 + 16'h3C5A);
    end
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!(m_st == 0 && q.size() == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    forever begin
      if (rq.size() == 0) break;
      rd_task = 1'b1;
      @(negedge clk);
    end
    rd_task = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) ;
  end

  bit auto_en = 1'b0;
  always @(negedge clk)
    rd_auto = auto_en && (m_st == 1) && (m_cnt == int'(cfg_div)) &&
              (m_e == 2 * (int'(cfg_bits_m1) + 1) - 1);

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cs_n == 1'b1 && sclk == cfg_cpol && tx_level == 0 && !tx_full && rx_empty && !rx_ovf,
        "R1 reset state", {cs_n, sclk, tx_full, rx_empty, rx_ovf}, 5'b10010);

    // R2: single word starts on its own
    set_cfg(8, 1, 0);
    write_words(1, 1);
    wait_idle();
    drain();
    chk(dut_reads == 1, "R8 one word per word", dut_reads, 1);

    // R4: three queued words, one frame
    dut_reads = 0;
    write_words(3, 2);
    wait_idle();
    drain();
    chk(dut_reads == 3, "R4 three words framed", dut_reads, 3);

    // R7 mode 3, 16-bit, a word added mid-transfer
    set_cfg(16, 2, 3);
    write_words(1, 3);
    repeat (10) @(negedge clk);
    write_words(1, 4);
    wait_idle();
    drain();

    // R6 odd length, mode 1, fastest rate
    set_cfg(5, 0, 1);
    write_words(2, 5);
    wait_idle();
    drain();

    // R3 mode 2, 12-bit, slow rate
    set_cfg(12, 3, 2);
    write_words(1, 6);
    wait_idle();
    drain();

    // R9/R10/R11: flood the transmit queue, overflow the receive queue
    set_cfg(8, 0, 0);
    dut_reads = 0;
    write_words(20, 7);
    wait_idle();
    chk(rx_ovf == 1'b1, "R10 overflow flag", int'(rx_ovf), 1);
    drain();
    chk(dut_reads == 16, "R10 kept words", dut_reads, 16);

    // R10: read on empty has no effect
    rd_task = 1'b1;
    @(negedge clk);
    rd_task = 1'b0;
    @(negedge clk);
    chk(rx_empty == 1'b1 && rx_ovf == 1'b1, "R10 empty read", {rx_empty, rx_ovf}, 2'b11);

    // R11: receive read coinciding with a store while full
    write_words(16, 8);
    wait_idle();
    auto_en = 1'b1;
    write_words(1, 9);
    wait_idle();
    auto_en = 1'b0;
    @(negedge clk);
    chk(rq.size() == 16 && !rx_empty, "R11 read and store", rq.size(), 16);
    dut_reads = 0;
    drain();
    chk(dut_reads == 16, "R11 drained words", dut_reads, 16);

    finish_run();
  end
endmodule